// File: doc/BRIEF.md
# Flash Program and Erase Engine

This block holds a byte-addressed flash array and carries out the three operations that change it. A program request can only clear bits: each addressed byte is replaced by the AND of its old value and the new data. A sector erase sets every byte of the aligned sector to 0xFF. A chip erase sets every byte of the array to 0xFF. Command decoding and read multiplexing belong to the surrounding logic. That logic presents an operation code, a size, an address and data, and it reads the array back through a plain combinational read port.

Program completes in the cycle after it is accepted. An erase first fills its range at one byte per clock. It then waits out a busy period, and the chip-erase period is ten times the sector-erase period. A one-cycle done pulse marks the end of the erase, and in the same cycle bit 7 of the status byte inverts. The engine ignores every request while it is busy. The array length and sector length are powers of two set by parameters. Addresses wrap modulo the array length.

Top module: `fpe_engine`

## Requirements
- R1: After reset, every array byte reads 0xFF, `status` is 0x00, and `busy` and `done` are low.
- R2: A program request (`req_op` = 2'b01) accepted while idle ANDs data byte k (`req_data[8k+7:8k]`) into array byte `req_addr`+k, for k below n. The byte count n is 1 for `req_size` 2'b00, 2 for 2'b01 and 4 for 2'b1x. The new contents are readable in the next cycle, every other byte is unchanged, and `busy` stays low.
- R3: In the cycle after a program is accepted, `status` equals {~`req_data[7]`, 7'h7F}. No done pulse is produced.
- R4: A sector erase (`req_op` = 2'b10) clears `status` to 0x00 and raises `busy` in the next cycle. It sets to 0xFF every byte from `req_addr` rounded down to a multiple of SECTOR_BYTES through the end of that sector, and leaves all other bytes unchanged.
- R5: A chip erase (`req_op` = 2'b11) clears `status` to 0x00, raises `busy` and sets every array byte to 0xFF.
- R6: `busy` stays high for exactly SECTOR_BYTES + SECTOR_BUSY_CYCLES cycles after a sector erase is accepted, and for CHIP_BYTES + 10*SECTOR_BUSY_CYCLES cycles after a chip erase is accepted.
- R7: `done` is high for exactly one cycle, which is the first cycle in which `busy` is low after an erase. In that same cycle `status` bit 7 has inverted, so `status` reads 0x80.
- R8: While `busy` is high, program and erase requests have no effect on the array, on `status` or on the length of the busy period.
- R9: Only the low log2(CHIP_BYTES) bits of `req_addr` and `rd_addr` are used. A multi-byte program that runs past the last byte continues at byte 0.
- R10: A request with `req_op` = 2'b00 changes neither the array nor `status`.
- R11: A request presented in the cycle in which `done` is high is accepted like any request made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 none, 01 program, 10 sector erase, 11 chip erase |
| req_size | input | 2 | Program byte count: 00 one, 01 two, 1x four |
| req_addr | input | ADDR_W | Byte address, taken modulo CHIP_BYTES |
| req_data | input | 32 | Program data, byte k at bits 8k+7:8k |
| busy | output | 1 | Erase fill or busy period in progress |
| done | output | 1 | One-cycle pulse at the end of an erase |
| status | output | 8 | Status byte |
| rd_addr | input | ADDR_W | Read address, taken modulo CHIP_BYTES |
| rd_data | output | 8 | Array byte at rd_addr, combinational |

## Verification
The end of an erase and the acceptance of a new request can occur in the same cycle. In that cycle `done` pulses and `status` bit 7 flips, and a request arriving then must be taken at once. The bench provokes this by holding a program request high for the whole of a chip erase. Every cycle of that request before the end of the erase must be ignored. The program must take effect exactly once, at the edge that follows the done cycle. This is judged from `status` returning to the program value in place of 0x80, from `busy` staying low, and from a full read-back of the array in which only the programmed byte differs from 0xFF.

// File: rtl/fpe_pkg.sv
// Shared encodings of the flash program and erase engine.
package fpe_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } fpe_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_FILL = 2'b01,
        ST_WAIT = 2'b10
    } fpe_state_e;

    localparam int LANES = 4;
    localparam int CHIP_BUSY_MULT = 10;
endpackage

// File: rtl/fpe_lanes.sv
// Program lane decode: expands one program request into per-byte
// write enables, wrapped byte addresses and data bytes.
// Assumes the incoming address has already been reduced modulo the array size.
module fpe_lanes #(
    parameter int AW = 8
) (
    input  logic                                   en,
    input  logic [1:0]                             size,
    input  logic [AW-1:0]                          base,
    input  logic [8*fpe_pkg::LANES-1:0]            data,
    output logic [fpe_pkg::LANES-1:0]              we,
    output logic [fpe_pkg::LANES-1:0][AW-1:0]      addr,
    output logic [fpe_pkg::LANES-1:0][7:0]         bytes
);
    logic [fpe_pkg::LANES-1:0] mask;

    // Byte count from the size code.
    always_comb begin
        case (size)
            2'b00:   mask = 4'b0001;
            2'b01:   mask = 4'b0011;
            default: mask = 4'b1111;
        endcase
        we = en ? mask : '0;
    end

    // One address and data byte per lane; addresses wrap at the array end.
    for (genvar k = 0; k < fpe_pkg::LANES; k++) begin : g_lane
        assign addr[k]  = base + AW'(k);
        assign bytes[k] = data[8*k +: 8];
    end
endmodule

// File: rtl/fpe_array.sv
// Flash storage array held in flops. Program lanes AND into bytes, the
// fill port writes 0xFF, reset restores the erased state.
// Assumes the lane addresses are distinct and never coincide with a fill write.
module fpe_array #(
    parameter int CHIP_BYTES = 256,
    localparam int AW = $clog2(CHIP_BYTES)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [fpe_pkg::LANES-1:0]              lane_we,
    input  logic [fpe_pkg::LANES-1:0][AW-1:0]      lane_addr,
    input  logic [fpe_pkg::LANES-1:0][7:0]         lane_data,
    input  logic                                   fill_we,
    input  logic [AW-1:0]                          fill_addr,
    input  logic [AW-1:0]                          rd_idx,
    output logic [7:0]                             rd_byte
);
    logic [7:0] mem_q [CHIP_BYTES];
    logic [7:0] mem_d [CHIP_BYTES];

    // Next contents: bits may only be cleared by a program, set by a fill.
    always_comb begin
        mem_d = mem_q;
        for (int k = 0; k < fpe_pkg::LANES; k++) begin
            if (lane_we[k]) begin
                mem_d[lane_addr[k]] = mem_q[lane_addr[k]] & lane_data[k];
            end
        end
        if (fill_we) begin
            mem_d[fill_addr] = 8'hFF;
        end
    end

    // Storage register; reset leaves every byte erased.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CHIP_BYTES; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // Combinational read port.
    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/fpe_seq.sv
// Operation sequencer: accepts requests while idle, walks the erase fill
// one byte per clock, counts the busy period and keeps the status byte.
// Assumes SECTOR_BYTES < CHIP_BYTES, both powers of two, SECTOR_BUSY_CYCLES >= 1.
module fpe_seq #(
    parameter int CHIP_BYTES         = 256,
    parameter int SECTOR_BYTES       = 32,
    parameter int SECTOR_BUSY_CYCLES = 20,
    localparam int AW        = $clog2(CHIP_BYTES),
    localparam int CHIP_BUSY = fpe_pkg::CHIP_BUSY_MULT * SECTOR_BUSY_CYCLES,
    localparam int CW        = (CHIP_BUSY > 2) ? $clog2(CHIP_BUSY) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  fpe_pkg::fpe_op_e      req_op,
    input  logic [AW-1:0]         base,
    input  logic                  prog_msb,
    output logic                  prog_en,
    output logic                  fill_we,
    output logic [AW-1:0]         fill_addr,
    output logic                  busy,
    output logic                  done,
    output logic [7:0]            status
);
    import fpe_pkg::*;

    fpe_state_e    state;
    logic [AW-1:0] fill_ptr;
    logic [AW-1:0] fill_left;
    logic [CW-1:0] wait_cnt;
    logic          is_chip;
    logic          accept;
    logic          erase_go;
    logic [AW-1:0] sect_base;

    // Request acceptance and sector alignment.
    assign accept    = (state == ST_IDLE) && req_valid;
    assign prog_en   = accept && (req_op == OP_PROG);
    assign erase_go  = accept && ((req_op == OP_SECT) || (req_op == OP_CHIP));
    assign sect_base = base & ~AW'(SECTOR_BYTES - 1);
    assign fill_we   = (state == ST_FILL);
    assign fill_addr = fill_ptr;
    assign busy      = (state != ST_IDLE);

    // Sequencer state, counters, status byte and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fill_ptr  <= '0;
            fill_left <= '0;
            wait_cnt  <= '0;
            is_chip   <= 1'b0;
            status    <= 8'h00;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (prog_en) begin
                        status <= {~prog_msb, 7'h7F};
                    end else if (erase_go) begin
                        status    <= 8'h00;
                        state     <= ST_FILL;
                        is_chip   <= (req_op == OP_CHIP);
                        fill_ptr  <= (req_op == OP_CHIP) ? '0 : sect_base;
                        fill_left <= (req_op == OP_CHIP) ? AW'(CHIP_BYTES - 1)
                                                         : AW'(SECTOR_BYTES - 1);
                    end
                end
                ST_FILL: begin
                    fill_ptr <= fill_ptr + 1'b1;
                    if (fill_left == '0) begin
                        state    <= ST_WAIT;
                        wait_cnt <= is_chip ? CW'(CHIP_BUSY - 1)
                                            : CW'(SECTOR_BUSY_CYCLES - 1);
                    end else begin
                        fill_left <= fill_left - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt == '0) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        status[7] <= ~status[7];
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpe_engine.sv
// Flash program and erase engine top: address wrap, program lane decode,
// sequencer and storage array.
// Assumes the parameter limits stated in fpe_seq.
module fpe_engine #(
    parameter int CHIP_BYTES         = 256,
    parameter int SECTOR_BYTES       = 32,
    parameter int SECTOR_BUSY_CYCLES = 20,
    parameter int ADDR_W             = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_data,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    import fpe_pkg::*;
    localparam int AW = $clog2(CHIP_BYTES);

    logic [AW-1:0]               base;
    logic [AW-1:0]               rd_idx;
    logic                        prog_en;
    logic                        fill_we;
    logic [AW-1:0]               fill_addr;
    logic [LANES-1:0]            lane_we;
    logic [LANES-1:0][AW-1:0]    lane_addr;
    logic [LANES-1:0][7:0]       lane_data;
    logic                        unused_hi;

    // Addresses wrap modulo the array length.
    assign base      = req_addr[AW-1:0];
    assign rd_idx    = rd_addr[AW-1:0];
    assign unused_hi = ^{req_addr[ADDR_W-1:AW], rd_addr[ADDR_W-1:AW]};

    fpe_seq #(
        .CHIP_BYTES         (CHIP_BYTES),
        .SECTOR_BYTES       (SECTOR_BYTES),
        .SECTOR_BUSY_CYCLES (SECTOR_BUSY_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (fpe_op_e'(req_op)),
        .base      (base),
        .prog_msb  (req_data[7]),
        .prog_en   (prog_en),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .busy      (busy),
        .done      (done),
        .status    (status)
    );

    fpe_lanes #(.AW(AW)) u_lanes (
        .en    (prog_en),
        .size  (req_size),
        .base  (base),
        .data  (req_data),
        .we    (lane_we),
        .addr  (lane_addr),
        .bytes (lane_data)
    );

    fpe_array #(.CHIP_BYTES(CHIP_BYTES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .lane_addr (lane_addr),
        .lane_data (lane_data),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .rd_idx    (rd_idx),
        .rd_byte   (rd_data)
    );
endmodule

// File: rtl/fpe_engine_chk.sv
// Protocol checker for fpe_engine, attached by bind. Observes ports only;
// the busy-length window is measured with a counter.
module fpe_engine_chk #(
    parameter int CHIP_BYTES         = 256,
    parameter int SECTOR_BYTES       = 32,
    parameter int SECTOR_BUSY_CYCLES = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic [7:0] req_data_lo,
    input logic       busy,
    input logic       done,
    input logic [7:0] status
);
    localparam int SECT_LEN = SECTOR_BYTES + SECTOR_BUSY_CYCLES;
    localparam int CHIP_LEN = CHIP_BYTES + 10 * SECTOR_BUSY_CYCLES;

    int   run_len;
    int   exp_len;
    logic erase_acc;

    assign erase_acc = !busy && req_valid && req_op[1];

    // Busy-cycle counter and expected length of the running erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
            exp_len <= 0;
        end else if (erase_acc) begin
            run_len <= 0;
            exp_len <= req_op[0] ? CHIP_LEN : SECT_LEN;
        end else if (busy) begin
            run_len <= run_len + 1;
        end
    end

    assert_prog_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op == 2'b01) |=>
            (!busy && !done && status == {~$past(req_data_lo[7]), 7'h7F}));

    assert_erase_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_acc |=> (busy && status == 8'h00));

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == exp_len));

    assert_done_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && status == 8'h80));

    assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(status)));

    assert_take_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid && req_op[1]) |=> busy);
endmodule

bind fpe_engine fpe_engine_chk #(
    .CHIP_BYTES         (CHIP_BYTES),
    .SECTOR_BYTES       (SECTOR_BYTES),
    .SECTOR_BUSY_CYCLES (SECTOR_BUSY_CYCLES)
) u_fpe_engine_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_data_lo (req_data[7:0]),
    .busy        (busy),
    .done        (done),
    .status      (status)
);

// File: tb/test_fpe_engine.sv
`timescale 1ns/1ps
module test_fpe_engine;
    localparam int CHIP = 256;
    localparam int SECT = 32;
    localparam int SBSY = 20;
    localparam int NVEC = 8;

    // Vector: {op[1:0], size[1:0], addr[31:0], data[31:0]}
    localparam logic [67:0] VEC [NVEC] = '{
        {2'b01, 2'b00, 32'h0000_0010, 32'h0000_005A},
        {2'b01, 2'b00, 32'h0000_0010, 32'h0000_00F0},
        {2'b01, 2'b00, 32'h0000_0010, 32'h0000_00FF},
        {2'b01, 2'b01, 32'h0000_0020, 32'hFFFF_8034},
        {2'b01, 2'b10, 32'h0000_0044, 32'h8765_43A1},
        {2'b01, 2'b10, 32'hABCD_01FE, 32'h0C0D_0E0F},
        {2'b00, 2'b10, 32'h0000_0050, 32'h0000_0000},
        {2'b01, 2'b11, 32'h0000_0060, 32'h1111_1111}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic [31:0] req_data;
    logic        busy;
    logic        done;
    logic [7:0]  status;
    logic [31:0] rd_addr;
    logic [7:0]  rd_data;

    int          n_run  = 0;
    int          n_fail = 0;
    logic [7:0]  model [CHIP];
    logic [7:0]  exp_status;

    always #2 clk = ~clk;

    fpe_engine #(
        .CHIP_BYTES(CHIP), .SECTOR_BYTES(SECT),
        .SECTOR_BUSY_CYCLES(SBSY), .ADDR_W(32)
    ) i_fpe_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .status(status),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of a program: AND the data bytes into wrapped addresses.
    task automatic model_prog(input logic [1:0] size, input logic [31:0] addr,
                              input logic [31:0] data);
        int nb = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
        for (int k = 0; k < nb; k++) begin
            model[(addr + k) % CHIP] &= data[8*k +: 8];
        end
        exp_status = {~data[7], 7'h7F};
    endtask

    // Full read-back through the read port, one byte per cycle.
    task automatic compare_mem(input string req);
        int bad = 0;
        logic [7:0] fa = 8'h00, fe = 8'h00;
        logic [31:0] fx = 0;
        for (int a = 0; a < CHIP; a++) begin
            @(negedge clk);
            rd_addr = 32'h5A00_0000 | (a * 32'h101);
            #1;
            if (rd_data !== model[a]) begin
                if (bad == 0) begin fa = rd_data; fe = model[a]; fx = a; end
                bad++;
            end
        end
        chk(bad == 0, req, {fx[15:0], 8'h00, fa}, {fx[15:0], 8'h00, fe});
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] size,
                         input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_size = size;
        req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Erase with optional stimulus during busy.
    // mode 0: none; 1: requests during busy (ignored); 2: program held through done.
    task automatic run_erase(input logic [1:0] op, input logic [31:0] addr,
                             input int exp_len, input int mode,
                             input logic [31:0] paddr, input logic [7:0] pdata);
        int n = 1;
        logic [31:0] base;
        issue(op, 2'b00, addr, 32'h0);
        chk(busy === 1'b1 && status === 8'h00, "R4", {23'd0, busy, status}, 32'h100);
        while (busy && n < 5000) begin
            if (mode == 1) begin
                if (n == 5) begin
                    req_valid = 1'b1; req_op = 2'b01; req_size = 2'b00;
                    req_addr = paddr; req_data = {24'h0, pdata};
                end else if (n == 6) begin
                    req_op = 2'b11;
                end else if (n == 7) begin
                    req_valid = 1'b0;
                end
            end else if (mode == 2) begin
                req_valid = 1'b1; req_op = 2'b01; req_size = 2'b00;
                req_addr = paddr; req_data = {24'h0, pdata};
            end
            @(negedge clk);
            if (busy) n++;
        end
        chk(n == exp_len, "R6", n, exp_len);
        chk(done === 1'b1, "R7", {31'd0, done}, 1);
        chk(status === 8'h80, "R7", {24'd0, status}, 32'h80);
        @(negedge clk);
        req_valid = 1'b0;
        chk(done === 1'b0, "R7", {31'd0, done}, 0);
        if (op == 2'b11) begin
            for (int a = 0; a < CHIP; a++) model[a] = 8'hFF;
        end else begin
            base = (addr % CHIP) & ~(SECT - 1);
            for (int a = 0; a < SECT; a++) model[base + a] = 8'hFF;
        end
        exp_status = 8'h80;
        if (mode == 2) begin
            model_prog(2'b00, paddr, {24'h0, pdata});
            chk(status === exp_status && busy === 1'b0, "R11",
                {23'd0, busy, status}, {24'd0, exp_status});
        end else begin
            chk(status === exp_status, "R8", {24'd0, status}, {24'd0, exp_status});
        end
        compare_mem(op == 2'b11 ? "R5" : "R4");
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_size = 2'b00;
        req_addr = 0; req_data = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1", {30'd0, busy, done}, 0);
        chk(status === 8'h00, "R1", {24'd0, status}, 0);
        for (int a = 0; a < CHIP; a++) model[a] = 8'hFF;
        exp_status = 8'h00;
        compare_mem("R1");

        // Table of program and no-op vectors (R2, R3, R9, R10)
        for (int v = 0; v < NVEC; v++) begin
            issue(VEC[v][67:66], VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);
            if (VEC[v][67:66] == 2'b01) begin
                model_prog(VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);
            end
            chk(status === exp_status, VEC[v][67:66] == 2'b01 ? "R3" : "R10",
                {24'd0, status}, {24'd0, exp_status});
            chk(busy === 1'b0 && done === 1'b0, "R2", {30'd0, busy, done}, 0);
            compare_mem(v == 5 ? "R9" : "R2");
        end

        // Sector erase with requests injected while busy (R4, R6, R7, R8)
        run_erase(2'b10, 32'h0000_034B, SECT + SBSY, 1, 32'h10, 8'h00);
        // Chip erase with a program held through the done cycle (R5, R11)
        run_erase(2'b11, 32'h0000_0007, CHIP + 10 * SBSY, 2, 32'h0000_0133, 8'h0F);
        // Sector erase of the last sector, neighbour byte kept (R4, R9)
        issue(2'b01, 2'b01, 32'h0000_00DF, 32'h0000_0000);
        model_prog(2'b01, 32'h0000_00DF, 32'h0);
        run_erase(2'b10, 32'hFFFF_FFE5, SECT + SBSY, 0, 32'h0, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule